// File: doc/BRIEF.md
# Stochastic Frame-to-Address-Event Generator

This block turns a stored grayscale image into a continuous stream of address events. A host fills a pixel memory through a plain write port. A sweep engine then visits every pixel in raster order, one pixel per clock. On each visit it compares the stored intensity against a fresh pseudo-random byte taken from a linear-feedback shift register. If the compare passes, the pixel's address goes out on a valid/ready event port.

Bright pixels pass the compare more often than dim ones, so their share of the event bus grows with intensity. Because the random source is stepped on every visit, the spikes from each pixel are spread irregularly in time, much like a Poisson process, rather than coming as a fixed count-down train. The host may rewrite pixels at any time after start-up. A sweep already under way picks up each new value in place.

The engine is a three-state machine:
- **ST_CLEAR** zeroes the memory after reset. When its cursor reaches the last address it takes the transition *clear_done* into ST_SCAN.
- **ST_SCAN** makes one visit per cycle. On a passing compare it takes *fire* into ST_HOLD.
- **ST_HOLD** presents the event and waits. Once the event is accepted it takes *accept* back to ST_SCAN.

At the default 64 x 64 size a full sweep lasts 4096 cycles plus one cycle per event emitted. This is far faster than one sweep per 40 ms (25 new frames per second) at any practical clock.

Top module: `frame_spike_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first firing visit, `ev_valid` is low. Reset seeds the LFSR with the nonzero `LFSR_SEED` and points the cursor at address 0.
- R2: For the first 2^(ROW_W+COL_W) cycles after reset release (ST_CLEAR), every pixel is written to zero and host writes are ignored. The first visit happens in the cycle after that.
- R3: A visit fires if and only if the pixel intensity, taken as unsigned, is strictly greater than the low PIX_W bits of the current LFSR value. A zero pixel therefore never fires.
- R4: The LFSR is 16-bit Fibonacci. It shifts toward the MSB and takes as its new bit 0 the XOR of bits 15, 14, 12 and 3 (taps 16,15,13,4). A visit uses the value held before the step, and the LFSR steps exactly once per visit and at no other time.
- R5: In ST_SCAN one pixel is visited per cycle in raster order. The linear index is row*2^COL_W + col, and it wraps from the last pixel to 0.
- R6: `ev_valid` rises in the cycle after a firing visit, with `ev_addr` = {row, col} of that pixel (row in the upper ROW_W bits). Both hold unchanged while `ev_ready` is low.
- R7: If `ev_valid` and `ev_ready` are both high at a clock edge, `ev_valid` is low in the next cycle and visiting resumes at the pixel after the emitted one. No visit and no LFSR step happen while an event waits.
- R8: A host write in ST_SCAN or ST_HOLD updates the addressed pixel at that clock edge. Visits in later cycles use the new value, and a visit at that same edge uses the old one.
- R9: Over many sweeps, a pixel with higher intensity produces more accepted events than a pixel with lower intensity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_we | input | 1 | Pixel write strobe |
| pix_waddr | input | ROW_W+COL_W | Pixel write address {row, col} |
| pix_wdata | input | PIX_W | Pixel intensity to store |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Consumer accepts event |
| ev_addr | output | ROW_W+COL_W | Event address {row, col} |

## Verification
A corrupted LFSR or cursor does not show at once. The first sign is an event address, or an event timing, that departs from the reference sequence. With a ramp of intensities loaded, that happens within a handful of visits, since almost every compare outcome depends on the exact random byte and pixel. A wrong state register shows within a cycle or two: events leak during clearing, `ev_valid` drops without a handshake, or a stalled event's address drifts. The bench compares the event port against a cycle-by-cycle reference every cycle, so the first divergent visit is reported on the cycle that follows it.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_SCAN  = 2'd1,
        ST_HOLD  = 2'd2
    } fsg_state_e;

endpackage

// File: rtl/fsg_lfsr.sv
module fsg_lfsr #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'hD008,
    parameter logic [WIDTH-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] value
);

    localparam logic [WIDTH-1:0] SAFE_SEED = (SEED == '0) ? WIDTH'(1) : SEED;

    logic feedback;

    always_comb begin
        feedback = ^(value & TAPS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= SAFE_SEED;
        end else if (step) begin
            value <= {value[WIDTH-2:0], feedback};
        end
    end

endmodule

// File: rtl/fsg_pixel_store.sv
module fsg_pixel_store #(
    parameter int ADDR_W = 12,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [PIX_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [PIX_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [PIX_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = cells[raddr];
    end

endmodule

// File: rtl/fsg_sweep_fsm.sv
module fsg_sweep_fsm
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PIX_W  = 8,
    parameter int LFSR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] rnd,
    input  logic [PIX_W-1:0]  pix,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [PIX_W-1:0]  host_data,
    input  logic              ev_ready,
    output fsg_state_e        state,
    output logic [ADDR_W-1:0] cursor,
    output logic              rnd_step,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [PIX_W-1:0]  mem_wdata,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    fsg_state_e nxt_state;
    logic       fire;

    always_comb begin
        fire = (state == ST_SCAN) && (pix > rnd[PIX_W-1:0]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAR;
        end else begin
            state <= nxt_state;
        end
    end

    // transitions: clear_done, fire, accept
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_CLEAR: if (cursor == LAST_ADDR) nxt_state = ST_SCAN;
            ST_SCAN:  if (fire)                nxt_state = ST_HOLD;
            ST_HOLD:  if (ev_ready)            nxt_state = ST_SCAN;
            default:                           nxt_state = ST_CLEAR;
        endcase
    end

    // registered outputs and cursor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cursor   <= '0;
            ev_valid <= 1'b0;
            ev_addr  <= '0;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    cursor <= cursor + ADDR_W'(1);
                end
                ST_SCAN: begin
                    cursor <= cursor + ADDR_W'(1);
                    if (fire) begin
                        ev_valid <= 1'b1;
                        ev_addr  <= cursor;
                    end
                end
                ST_HOLD: begin
                    if (ev_ready) begin
                        ev_valid <= 1'b0;
                    end
                end
                default: begin
                    ev_valid <= 1'b0;
                end
            endcase
        end
    end

    // memory write steering and random step
    always_comb begin
        rnd_step = (state == ST_SCAN);
        if (state == ST_CLEAR) begin
            mem_we    = 1'b1;
            mem_waddr = cursor;
            mem_wdata = '0;
        end else begin
            mem_we    = host_we;
            mem_waddr = host_addr;
            mem_wdata = host_data;
        end
    end

endmodule

// File: rtl/frame_spike_gen.sv
module frame_spike_gen
    import fsg_pkg::*;
#(
    parameter int                ROW_W     = 6,
    parameter int                COL_W     = 6,
    parameter int                PIX_W     = 8,
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_we,
    input  logic [ROW_W+COL_W-1:0] pix_waddr,
    input  logic [PIX_W-1:0]       pix_wdata,
    output logic                   ev_valid,
    input  logic                   ev_ready,
    output logic [ROW_W+COL_W-1:0] ev_addr
);

    localparam int ADDR_W = ROW_W + COL_W;

    fsg_state_e        st;
    logic [ADDR_W-1:0] cursor;
    logic [LFSR_W-1:0] rnd;
    logic              rnd_step;
    logic [PIX_W-1:0]  pix_rd;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [PIX_W-1:0]  mem_wdata;

    fsg_lfsr #(
        .WIDTH (LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rnd_step),
        .value (rnd)
    );

    fsg_pixel_store #(
        .ADDR_W (ADDR_W),
        .PIX_W  (PIX_W)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (cursor),
        .rdata (pix_rd)
    );

    fsg_sweep_fsm #(
        .ADDR_W (ADDR_W),
        .PIX_W  (PIX_W),
        .LFSR_W (LFSR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rnd       (rnd),
        .pix       (pix_rd),
        .host_we   (pix_we),
        .host_addr (pix_waddr),
        .host_data (pix_wdata),
        .ev_ready  (ev_ready),
        .state     (st),
        .cursor    (cursor),
        .rnd_step  (rnd_step),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .ev_valid  (ev_valid),
        .ev_addr   (ev_addr)
    );

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PIX_W  = 8,
    parameter int LFSR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input fsg_state_e        st,
    input logic [ADDR_W-1:0] cursor,
    input logic [LFSR_W-1:0] rnd,
    input logic [PIX_W-1:0]  pix_rd,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [ADDR_W-1:0] ev_addr
);

    assert_quiet_in_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLEAR) |-> !ev_valid);

    assert_pass_emits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCAN && pix_rd > rnd[PIX_W-1:0]) |=> (ev_valid && ev_addr == $past(cursor)));

    assert_zero_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCAN && pix_rd == '0) |=> !ev_valid);

    assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0);

    assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_addr)));

    assert_drop_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> !ev_valid);

    assert_wait_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |=> ($stable(rnd) && $stable(cursor)));

endmodule

bind frame_spike_gen fsg_checker #(
    .ADDR_W (ADDR_W),
    .PIX_W  (PIX_W),
    .LFSR_W (LFSR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .cursor   (cursor),
    .rnd      (rnd),
    .pix_rd   (pix_rd),
    .ev_valid (ev_valid),
    .ev_ready (ev_ready),
    .ev_addr  (ev_addr)
);

// File: tb/tb_frame_spike_gen.sv
module tb_frame_spike_gen;

    localparam int          ROW_W = 2;
    localparam int          COL_W = 2;
    localparam int          AW    = ROW_W + COL_W;
    localparam int          N     = 1 << AW;
    localparam logic [15:0] SEED  = 16'hACE1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_we = 1'b0;
    logic [AW-1:0] pix_waddr = '0;
    logic [7:0]    pix_wdata = '0;
    logic          ev_ready = 1'b1;
    logic          ev_valid;
    logic [AW-1:0] ev_addr;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    frame_spike_gen #(
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .PIX_W     (8),
        .LFSR_W    (16),
        .LFSR_SEED (SEED)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_we    (pix_we),
        .pix_waddr (pix_waddr),
        .pix_wdata (pix_wdata),
        .ev_valid  (ev_valid),
        .ev_ready  (ev_ready),
        .ev_addr   (ev_addr)
    );

    // reference model, built from the requirements
    int            m_phase;   // 0 clear, 1 scan, 2 wait
    logic [AW-1:0] m_cur;
    logic [15:0]   m_lfsr;
    logic          m_valid;
    logic [AW-1:0] m_addr;
    logic [7:0]    m_mem [N];
    int            cnt [N];
    logic          s_valid, s_ready;
    logic [AW-1:0] s_addr;
    logic          cmp_on = 1'b0;

    always @(posedge clk) begin
        int   old_phase;
        logic fb;
        cycles++;
        s_valid = ev_valid;
        s_ready = ev_ready;
        s_addr  = ev_addr;
        if (rst_n && ev_valid && ev_ready) cnt[ev_addr]++;
        if (!rst_n) begin
            m_phase = 0; m_cur = '0; m_lfsr = SEED; m_valid = 1'b0; m_addr = '0;
            for (int i = 0; i < N; i++) m_mem[i] = 8'd0;
        end else begin
            old_phase = m_phase;
            case (m_phase)
                0: begin
                    if (m_cur == AW'(N - 1)) m_phase = 1;
                    m_cur = m_cur + AW'(1);
                end
                1: begin
                    if (m_mem[m_cur] > m_lfsr[7:0]) begin
                        m_valid = 1'b1; m_addr = m_cur; m_phase = 2;
                    end
                    fb = m_lfsr[15] ^ m_lfsr[14] ^ m_lfsr[12] ^ m_lfsr[3];
                    m_lfsr = {m_lfsr[14:0], fb};
                    m_cur = m_cur + AW'(1);
                end
                default: begin
                    if (ev_ready) begin m_valid = 1'b0; m_phase = 1; end
                end
            endcase
            if (old_phase != 0 && pix_we) m_mem[pix_waddr] = pix_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check(ev_valid == m_valid, "R6 valid vs reference", int'(ev_valid), int'(m_valid));
            if (m_valid)
                check(ev_addr == m_addr, "R5 event address vs reference", int'(ev_addr), int'(m_addr));
            if (s_valid && !s_ready)
                check(ev_valid && ev_addr == s_addr, "R6 stalled event held", int'(ev_addr), int'(s_addr));
            if (s_valid && s_ready)
                check(!ev_valid, "R7 valid drops after accept", int'(ev_valid), 0);
        end
    end

    task automatic write_pix(input int a, input int d);
        @(negedge clk);
        pix_we = 1'b1; pix_waddr = AW'(a); pix_wdata = 8'(d);
        @(negedge clk);
        pix_we = 1'b0;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < N; i++) cnt[i] = 0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        int total;
        clear_counts();
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            check(ev_valid == 1'b0, "R1 valid low in reset", int'(ev_valid), 0);
        end
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R2: write during clearing is dropped
        write_pix(3, 255);
        repeat (N) @(negedge clk);
        clear_counts();
        repeat (4 * N) @(negedge clk);
        total = 0;
        for (int i = 0; i < N; i++) total += cnt[i];
        check(total == 0, "R2 no events from cleared memory", total, 0);
        check(ev_valid == 1'b0, "R1 idle after clear", int'(ev_valid), 0);

        // load ramp: pixel i gets i*16, pixel 0 stays zero
        for (int i = 0; i < N; i++) write_pix(i, i * 16);
        clear_counts();
        // R4 R5: free-running consumer
        repeat (3000) @(negedge clk);
        // R6 R7: consumer with stalls
        for (int k = 0; k < 3000; k++) begin
            ev_ready = !((k % 5 == 0) || (k % 7 == 3) || (k % 60 < 8));
            @(negedge clk);
        end
        ev_ready = 1'b1;
        @(negedge clk);
        check(cnt[0] == 0, "R3 zero pixel never fires", cnt[0], 0);
        check(cnt[15] > cnt[8], "R9 rate 240 above 128", cnt[15], cnt[8]);
        check(cnt[8] > cnt[1], "R9 rate 128 above 16", cnt[8], cnt[1]);
        check(cnt[1] > 0, "R3 intensity 16 fires sometimes", cnt[1], 1);

        // R8: in-place rewrites during the sweep
        write_pix(15, 0);
        write_pix(0, 255);
        repeat (3) @(negedge clk);
        clear_counts();
        repeat (1000) @(negedge clk);
        check(cnt[15] == 0, "R8 rewritten-to-zero pixel silent", cnt[15], 0);
        check(cnt[0] > 0, "R8 rewritten-to-255 pixel fires", cnt[0], 1);

        // R8: rewrite while an event waits
        ev_ready = 1'b0;
        repeat (40) @(negedge clk);
        write_pix(2, 200);
        repeat (5) @(negedge clk);
        ev_ready = 1'b1;
        repeat (500) @(negedge clk);
        check(cnt[2] > 0, "R8 pixel rewritten while stalled fires", cnt[2], 1);

        cmp_on = 1'b0;
        finish_run();
    end

    initial begin
        while (cycles < 150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        finish_run();
    end

endmodule